// File: doc/BRIEF.md
# Single-Error-Correcting Word Memory

A small synchronous memory of 8-bit words in which every word is stored together with four check bits of a Hamming single-error-correcting code. A write encodes the incoming byte and stores data and check bits side by side. A read recomputes the check bits from the stored data and XORs them with the stored check bits to form a 4-bit syndrome. The syndrome selects one of four outcomes: clean, check-bit fault, data fault (corrected), or a syndrome that names no position. The result is registered and appears one cycle after the read request.

Correction acts only on the read path. The stored word is never rewritten, so a fault stays in the array until the word is written again. A fault-injection input flips any one of the twelve stored code bits in place, so every syndrome class can be reached from the ports.

Top module: `ecc_word_mem`

## Requirements
- R1: A word written with `we` and later read with `re` returns the same byte on `rdData` with `errNone` set.
- R2: Code bit positions run from 1 to 12. Check bits sit at positions 1, 2, 4 and 8. Data bits `wrData[0]` to `wrData[7]` sit at positions 3, 5, 6, 7, 9, 10, 11 and 12 in that order. The check bit at position 2^j is the even parity of every data bit whose position has bit j set.
- R3: `rdValid`, `rdData` and the four flags update on the clock edge that follows the cycle in which `re` is high. The flags are all low whenever `rdValid` is low.
- R4: If exactly one data bit of a word has been flipped, the read returns the originally written byte with `errCorrected` set.
- R5: If exactly one check bit of a word has been flipped, the read returns the stored byte unchanged with `errCheck` set.
- R6: A syndrome of 13, 14 or 15 sets `errUncorr` and returns the stored data bits unchanged, including any flipped ones.
- R7: While `rdValid` is high, exactly one of `errNone`, `errCheck`, `errCorrected` and `errUncorr` is high.
- R8: A read does not repair the array. A second read of a faulty word reports the same class and returns the same byte.
- R9: `injEn` with `injPos` in the range 1 to 12 flips that code bit of the word at `addr`. It has no effect when `we` is high in the same cycle or when `injPos` is 0 or 13 to 15.
- R10: A read and a write to the same address in the same cycle return the word held before the write.
- R11: After reset `rdValid`, `rdData` and the flags are low, and every word reads as 0 with `errNone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| we | input | 1 | Write request |
| re | input | 1 | Read request |
| addr | input | 4 | Word address for read, write and injection |
| wrData | input | 8 | Byte to store |
| injEn | input | 1 | Fault-injection request |
| injPos | input | 4 | Code bit position to flip, 1 to 12 |
| rdData | output | 8 | Read result after correction |
| rdValid | output | 1 | Read result valid, one cycle after `re` |
| errNone | output | 1 | Syndrome was zero |
| errCheck | output | 1 | A single check bit was faulty |
| errCorrected | output | 1 | A data bit was inverted on output |
| errUncorr | output | 1 | Syndrome named no valid position |

## Verification
A wrong stored check bit or a wrong position map shows up at the very next read of that word. A clean word then reports a check or data fault, or an injected fault is repaired into the wrong bit, so `rdData` or the class flags differ from a reference encoder one cycle after `re`. A read path that wrote its correction back would show on a second read of a faulty word, which would then report a clean class. Every injection position, three of the unnamed syndromes, and the write and injection collision are each read back through the same one-cycle port.

// File: rtl/hmem_pkg.sv
package hmem_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic doWrite;
    logic doRead;
    logic doInject;
  } ctrlStrobes_t;

  // Read classification, one bit per class
  typedef struct packed {
    logic uncorr;
    logic corrected;
    logic check;
    logic none;
  } errFlags_t;

  // Smallest check width k with 2^k >= data + k + 1
  function automatic int chkWidth(input int dataW);
    int k;
    k = 1;
    while ((1 << k) < dataW + k + 1) k++;
    return k;
  endfunction

endpackage

// File: rtl/hmem_ctrl.sv
module hmem_ctrl
  import hmem_pkg::*;
#(
  parameter int CW_W  = 12,
  parameter int POS_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             re,
  input  logic             injEn,
  input  logic [POS_W-1:0] injPos,
  output ctrlStrobes_t     strb,
  output logic             rdValid
);

  logic posInRange;
  assign posInRange = (injPos != '0) && (injPos <= POS_W'(CW_W));

  // A write wins over an injection on the same cycle
  always_comb begin
    strb.doWrite  = !rst && we;
    strb.doRead   = !rst && re;
    strb.doInject = !rst && injEn && !we && posInRange;
  end

  always_ff @(posedge clk) begin
    if (rst) rdValid <= 1'b0;
    else     rdValid <= strb.doRead;
  end

  p_read_valid_r3: assert property (@(posedge clk) disable iff (rst)
    re |=> rdValid);

  p_write_beats_inject_r9: assert property (@(posedge clk) disable iff (rst)
    (we && injEn) |-> !strb.doInject);

endmodule

// File: rtl/hmem_datapath.sv
module hmem_datapath
  import hmem_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int CHK_W  = 4,
  parameter int POS_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [POS_W-1:0]  injPos,
  output logic [DATA_W-1:0] rdData,
  output errFlags_t         flags
);

  localparam int CW_W  = DATA_W + CHK_W;
  localparam int DEPTH = 1 << ADDR_W;

  // Code position of data bit idx: the idx-th position that is not a power of two
  function automatic int dataPos(input int idx);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int p = 1; p <= CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == idx) res = p;
        cnt++;
      end
    end
    return res;
  endfunction

  // Even parity per check group
  function automatic logic [CHK_W-1:0] encode(input logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] c;
    c = '0;
    for (int j = 0; j < CHK_W; j++)
      for (int i = 0; i < DATA_W; i++)
        if (((dataPos(i) >> j) & 1) == 1) c[j] = c[j] ^ d[i];
    return c;
  endfunction

  logic [DATA_W-1:0] dataMem [DEPTH];
  logic [CHK_W-1:0]  chkMem  [DEPTH];

  // Injection masks, one comparator per code bit
  logic [DATA_W-1:0] injDataMask;
  logic [CHK_W-1:0]  injChkMask;
  logic [DATA_W-1:0] fixMask;

  logic [DATA_W-1:0] rawData;
  logic [CHK_W-1:0]  rawChk;
  logic [CHK_W-1:0]  syndrome;
  errFlags_t         cls;

  assign rawData  = dataMem[addr];
  assign rawChk   = chkMem[addr];
  assign syndrome = rawChk ^ encode(rawData);

  always_comb begin
    cls = '0;
    if (syndrome == '0)                   cls.none      = 1'b1;
    else if ($onehot(syndrome))           cls.check     = 1'b1;
    else if (syndrome <= CHK_W'(CW_W))    cls.corrected = 1'b1;
    else                                  cls.uncorr    = 1'b1;
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_dataBit
    localparam logic [POS_W-1:0] INJ_AT = POS_W'(dataPos(i));
    localparam logic [CHK_W-1:0] SYN_AT = CHK_W'(dataPos(i));
    assign injDataMask[i] = (injPos == INJ_AT);
    assign fixMask[i]     = cls.corrected && (syndrome == SYN_AT);
  end

  for (genvar j = 0; j < CHK_W; j++) begin : g_chkBit
    localparam logic [POS_W-1:0] INJ_AT = POS_W'(1 << j);
    assign injChkMask[j] = (injPos == INJ_AT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) begin
        dataMem[k] <= '0;
        chkMem[k]  <= '0;
      end
    end else if (strb.doWrite) begin
      dataMem[addr] <= wrData;
      chkMem[addr]  <= encode(wrData);
    end else if (strb.doInject) begin
      dataMem[addr] <= rawData ^ injDataMask;
      chkMem[addr]  <= rawChk ^ injChkMask;
    end
  end

  // Output register: correction on the read path only
  always_ff @(posedge clk) begin
    if (rst) begin
      rdData <= '0;
      flags  <= '0;
    end else if (strb.doRead) begin
      rdData <= rawData ^ fixMask;
      flags  <= cls;
    end else begin
      flags  <= '0;
    end
  end

  p_write_clean_r1: assert property (@(posedge clk) disable iff (rst)
    $past(strb.doWrite) |->
      (chkMem[$past(addr)] == encode(dataMem[$past(addr)])));

  p_fix_one_bit_r4: assert property (@(posedge clk) disable iff (rst)
    flags.corrected |-> ($countones(rdData ^ $past(rawData)) == 1));

  p_pass_through_r6: assert property (@(posedge clk) disable iff (rst)
    (flags.none || flags.check || flags.uncorr) |-> (rdData == $past(rawData)));

endmodule

// File: rtl/ecc_word_mem.sv
module ecc_word_mem
  import hmem_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  localparam int CHK_W = chkWidth(DATA_W),
  localparam int POS_W = $clog2(DATA_W + CHK_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              injEn,
  input  logic [POS_W-1:0]  injPos,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              errNone,
  output logic              errCheck,
  output logic              errCorrected,
  output logic              errUncorr
);

  ctrlStrobes_t strb;
  errFlags_t    flags;

  hmem_ctrl #(.CW_W(DATA_W + CHK_W), .POS_W(POS_W)) u_ctrl (
    .clk(clk), .rst(rst), .we(we), .re(re),
    .injEn(injEn), .injPos(injPos),
    .strb(strb), .rdValid(rdValid)
  );

  hmem_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CHK_W(CHK_W), .POS_W(POS_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .addr(addr),
    .wrData(wrData), .injPos(injPos),
    .rdData(rdData), .flags(flags)
  );

  assign errNone      = flags.none;
  assign errCheck     = flags.check;
  assign errCorrected = flags.corrected;
  assign errUncorr    = flags.uncorr;

  p_one_class_r7: assert property (@(posedge clk) disable iff (rst)
    rdValid |-> $onehot({errUncorr, errCorrected, errCheck, errNone}));

  p_quiet_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !rdValid |-> ({errUncorr, errCorrected, errCheck, errNone} == 4'b0));

endmodule

// File: tb/tb_ecc_word_mem.sv
module tb_ecc_word_mem;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       we = 1'b0, re = 1'b0, injEn = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [3:0] injPos = '0;
  logic [7:0] rdData;
  logic       rdValid, errNone, errCheck, errCorrected, errUncorr;

  int nChecks = 0;
  int nErrors = 0;
  logic running = 1'b0;
  logic reAtEdge = 1'b0;

  always #5 clk = ~clk;

  ecc_word_mem dut (
    .clk(clk), .rst(rst), .we(we), .re(re), .addr(addr), .wrData(wrData),
    .injEn(injEn), .injPos(injPos), .rdData(rdData), .rdValid(rdValid),
    .errNone(errNone), .errCheck(errCheck), .errCorrected(errCorrected),
    .errUncorr(errUncorr)
  );

  // Flag vector order: {uncorr, corrected, check, none}
  localparam logic [3:0] F_NONE = 4'b0001, F_CHK = 4'b0010,
                         F_COR  = 4'b0100, F_UNC = 4'b1000;

  typedef struct { logic [7:0] d; logic [3:0] f; int req; } exp_t;
  exp_t q[$];
  logic [12:1] model [16];

  // Reference encoder from the position layout (R2)
  function automatic logic [12:1] refEncode(input logic [7:0] d);
    logic [12:1] c;
    logic x;
    int k;
    c = '0;
    k = 0;
    for (int p = 1; p <= 12; p++)
      if ((p & (p - 1)) != 0) begin c[p] = d[k]; k++; end
    for (int j = 0; j < 4; j++) begin
      x = 1'b0;
      for (int p = 1; p <= 12; p++)
        if ((p & (p - 1)) != 0 && ((p >> j) & 1) == 1) x = x ^ c[p];
      c[1 << j] = x;
    end
    return c;
  endfunction

  function automatic logic [7:0] refData(input logic [12:1] c);
    logic [7:0] d;
    int k;
    k = 0;
    d = '0;
    for (int p = 1; p <= 12; p++)
      if ((p & (p - 1)) != 0) begin d[k] = c[p]; k++; end
    return d;
  endfunction

  task automatic refDecode(input logic [12:1] c, output logic [7:0] d, output logic [3:0] f);
    logic [12:1] rc;
    logic [3:0]  syn;
    int          s;
    rc = refEncode(refData(c));
    for (int j = 0; j < 4; j++) syn[j] = c[1 << j] ^ rc[1 << j];
    s = int'(syn);
    d = refData(c);
    if (syn == 4'd0) f = F_NONE;
    else if ($countones(syn) == 1) f = F_CHK;
    else if (s <= 12) begin
      c[s] = ~c[s];
      d = refData(c);
      f = F_COR;
    end else f = F_UNC;
  endtask

  task automatic cyc(input logic w, input logic r, input logic i, input logic [3:0] a,
                     input logic [7:0] d, input logic [3:0] p, input int req);
    logic [7:0] ed;
    logic [3:0] ef;
    @(negedge clk);
    we = w; re = r; injEn = i; addr = a; wrData = d; injPos = p;
    if (r) begin
      refDecode(model[a], ed, ef);
      q.push_back('{ed, ef, req});
    end
    if (w) model[a] = refEncode(d);
    else if (i && p >= 4'd1 && p <= 4'd12) model[a][p] = ~model[a][p];
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    cyc(1'b1, 1'b0, 1'b0, a, d, 4'd0, 1);
  endtask
  task automatic rd(input logic [3:0] a, input int req);
    cyc(1'b0, 1'b1, 1'b0, a, 8'h00, 4'd0, req);
  endtask
  task automatic inj(input logic [3:0] a, input logic [3:0] p);
    cyc(1'b0, 1'b0, 1'b1, a, 8'h00, p, 9);
  endtask
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(1'b0, 1'b0, 1'b0, 4'd0, 8'h00, 4'd0, 0);
  endtask

  always @(posedge clk) reAtEdge <= re && !rst;

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (running && !rst) begin
      if (rdValid !== reAtEdge) begin  // R3 latency
        nChecks++; nErrors++;
        $display("FAIL R3 rdValid actual=%0b expected=%0b", rdValid, reAtEdge);
      end
      if (rdValid) begin
        if (q.size() == 0) begin
          nChecks++; nErrors++;
          $display("FAIL R3 unexpected rdValid actual=1 expected=0");
        end else begin
          exp_t e;
          logic [3:0] fl;
          e = q.pop_front();
          fl = {errUncorr, errCorrected, errCheck, errNone};
          nChecks++;
          if (rdData !== e.d || fl !== e.f) begin
            nErrors++;
            $display("FAIL R%0d data/flags actual=%h/%b expected=%h/%b",
                     e.req, rdData, fl, e.d, e.f);
          end
        end
      end else if ({errUncorr, errCorrected, errCheck, errNone} !== 4'b0) begin
        nChecks++; nErrors++;  // R3 flags quiet while idle
        $display("FAIL R3 idle flags actual=%b expected=0000",
                 {errUncorr, errCorrected, errCheck, errNone});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    for (int k = 0; k < 16; k++) model[k] = '0;
    // R11: outputs low during reset, even with a read request
    re = 1'b1;
    repeat (3) @(negedge clk);
    nChecks++;
    if ({rdValid, rdData, errUncorr, errCorrected, errCheck, errNone} !== 13'd0) begin
      nErrors++;
      $display("FAIL R11 reset outputs actual=%b%h%b expected=0", rdValid, rdData,
               {errUncorr, errCorrected, errCheck, errNone});
    end
    re = 1'b0;
    rst = 1'b0;
    running = 1'b1;

    // R11: cleared array reads 0 clean
    rd(4'd0, 11);
    rd(4'd15, 11);

    // R1: plain write/read with varied patterns, back-to-back reads
    for (int a = 0; a < 16; a++) wr(4'(a), 8'(a * 37 + 5));
    wr(4'd6, 8'hFF);
    wr(4'd7, 8'hA5);
    wr(4'd8, 8'h80);
    for (int a = 0; a < 16; a++) rd(4'(a), 1);

    // R2 R4 R5 R8: every single-position fault, read twice
    for (int p = 1; p <= 12; p++) begin
      wr(4'd2, 8'hC3);
      inj(4'd2, 4'(p));
      rd(4'd2, ((p & (p - 1)) == 0) ? 5 : 4);
      rd(4'd2, 8);
    end
    for (int p = 1; p <= 12; p++) begin
      wr(4'd9, 8'h00);
      inj(4'd9, 4'(p));
      rd(4'd9, 2);
    end

    // R6: syndromes 13, 14, 15 and 13 via a data+check pair
    wr(4'd3, 8'h96); inj(4'd3, 4'd5); inj(4'd3, 4'd8); rd(4'd3, 6);
    wr(4'd3, 8'h96); inj(4'd3, 4'd6); inj(4'd3, 4'd8); rd(4'd3, 6);
    wr(4'd3, 8'h3C); inj(4'd3, 4'd7); inj(4'd3, 4'd8); rd(4'd3, 6);
    wr(4'd3, 8'h5A); inj(4'd3, 4'd4); inj(4'd3, 4'd9); rd(4'd3, 6);
    rd(4'd3, 7);  // R7 checked on every read via flag compare

    // R9: write wins over injection; out-of-range positions ignored
    cyc(1'b1, 1'b0, 1'b1, 4'd4, 8'h3C, 4'd3, 9);
    rd(4'd4, 9);
    inj(4'd4, 4'd0);  rd(4'd4, 9);
    inj(4'd4, 4'd13); rd(4'd4, 9);
    inj(4'd4, 4'd15); rd(4'd4, 9);

    // R10: read during write returns old word
    wr(4'd5, 8'h11);
    cyc(1'b1, 1'b1, 1'b0, 4'd5, 8'h22, 4'd0, 10);
    rd(4'd5, 10);

    idle(4);
    nChecks++;
    if (q.size() != 0) begin  // R3: every read produced a result
      nErrors++;
      $display("FAIL R3 pending reads actual=%0d expected=0", q.size());
    end
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule